// File: doc/BRIEF.md
# Two-Line Interrupt Flag Controller

This block gathers many single-bit event signals from a peripheral into two interrupt outputs. A rising edge on an event input sets a sticky flag for that event. The flag stays set until the host writes a one to its bit position. Writing a zero leaves the flag alone. A host that needs to know what happened reads the flag register, handles the event and then clears the flag.

Each flag passes through a per-flag enable mask. A per-flag route bit then sends it to line 0 or line 1. Each line has its own master enable. A line output is the OR of every enabled flag routed to it, gated by that line's enable and registered once. The host reaches the flag, enable, route and line-enable registers through a simple word-wide register port. Writes are synchronous. Reads are combinational from the selected address.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A flag bit is set on the clock edge at which its event input is high and was low on the previous edge. An event held high sets the flag only once, and after a clear it does not set it again until the event falls and rises.
- R2: A set flag stays set while there is no clearing write to it, whatever its event input does.
- R3: A write to address 0 (flag register) clears each flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R4: While rst_n is low, all flags, the enable, route and line-enable registers, and both interrupt outputs are 0.
- R5: A flag whose bit in the enable register (address 1) is 0 drives neither interrupt output.
- R6: A route bit of 0 in the route register (address 2) sends the flag to irq_o[0]. A route bit of 1 sends it to irq_o[1].
- R7: Bit 0 of the line-enable register (address 3) gates irq_o[0] and bit 1 gates irq_o[1]. A line whose enable is 0 stays low.
- R8: When a rising event edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Each interrupt output is registered. It reflects the flags and configuration of the previous cycle, one clock after a flag is set.
- R10: Reads return the register at rd_addr. Register bits above bit 23 (flags, enable, route) and above bit 1 (line enable) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 24 | Event inputs, one per flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 flags, 1 enable, 2 route, 3 line enable |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 32 | Read data, unused bits zero |
| irq_o | output | 2 | Interrupt lines 0 and 1 |

## Verification
A vector table pulses single and paired event bits under different combinations of enable mask, route pattern and line enables. It covers all flags on one line, all on the other, a masked flag with the line enabled, a flag on a disabled line, and a split route where one flag reaches each line. Each vector shows whether the enable, the route bit or the line enable decides the outcome. Directed tests then hold an event high across a clear to separate edge detection from level detection, and write zeros and single ones to the flag register. They also race a clear against a new edge, check the one-cycle output latency, and apply a reset partway through a run.

// File: rtl/irq_flag_pkg.sv
// Package: shared sizes and register addresses for the interrupt flag controller.
// Assumes a 2-bit word address space with four registers.
package irq_flag_pkg;
    localparam int unsigned NUM_LINES = 2;
    localparam int unsigned ADDR_W    = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAGS  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ROUTE  = 2'd2,
        REG_LINEEN = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/ifc_edge_detect.sv
// Module: rising-edge detector for a vector of event inputs.
// Assumes the events are synchronous to clk. The history resets to 0, so an
// event already high when reset is released counts as an edge.
module ifc_edge_detect #(
    parameter int unsigned WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    // Keep last cycle's event levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= evt_i;
    end

    // An edge is a high level that was low one cycle earlier.
    always_comb rise_o = evt_i & ~prev_q;
endmodule

// File: rtl/ifc_flag_bank.sv
// Module: sticky flag bits, set by event edges, cleared by write-one.
// Assumes clr_i is already qualified by a write to the flag address.
// Set takes priority over clear on the same bit.
module ifc_flag_bank #(
    parameter int unsigned WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flags_o
);
    logic [WIDTH-1:0] flags_q;

    // Per-bit update: clear first, then OR in new edges so set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    // Expose the flag state.
    always_comb flags_o = flags_q;
endmodule

// File: rtl/ifc_cfg_regs.sv
// Module: host-visible enable, route and line-enable registers plus read mux.
// Assumes single-cycle writes and combinational reads. Unused bits read 0.
module ifc_cfg_regs
    import irq_flag_pkg::*;
#(
    parameter int unsigned NFLAG  = 24,
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [NFLAG-1:0]     flags_i,
    output logic [NFLAG-1:0]     clr_o,
    output logic [NFLAG-1:0]     enable_o,
    output logic [NFLAG-1:0]     route_o,
    output logic [NUM_LINES-1:0] lineen_o,
    output logic [DATA_W-1:0]    rd_data
);
    logic [NFLAG-1:0]     enable_q;
    logic [NFLAG-1:0]     route_q;
    logic [NUM_LINES-1:0] lineen_q;

    // Store configuration words on writes to their addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            route_q  <= '0;
            lineen_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_ENABLE: enable_q <= wr_data[NFLAG-1:0];
                REG_ROUTE:  route_q  <= wr_data[NFLAG-1:0];
                REG_LINEEN: lineen_q <= wr_data[NUM_LINES-1:0];
                default:    ;
            endcase
        end
    end

    // Clear mask for the flag bank: the data word on a flag-address write.
    always_comb begin
        if (wr_en && reg_addr_e'(wr_addr) == REG_FLAGS) clr_o = wr_data[NFLAG-1:0];
        else                                           clr_o = '0;
    end

    // Read mux with zero-extension of every register.
    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            REG_FLAGS:  rd_data[NFLAG-1:0]     = flags_i;
            REG_ENABLE: rd_data[NFLAG-1:0]     = enable_q;
            REG_ROUTE:  rd_data[NFLAG-1:0]     = route_q;
            REG_LINEEN: rd_data[NUM_LINES-1:0] = lineen_q;
            default:    rd_data = '0;
        endcase
    end

    // Drive configuration outputs.
    always_comb begin
        enable_o = enable_q;
        route_o  = route_q;
        lineen_o = lineen_q;
    end
endmodule

// File: rtl/ifc_line_merge.sv
// Module: reduces masked flags to two registered interrupt lines.
// Assumes route bit 0 selects line 0 and route bit 1 selects line 1.
module ifc_line_merge
    import irq_flag_pkg::*;
#(
    parameter int unsigned NFLAG = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NFLAG-1:0]     flags_i,
    input  logic [NFLAG-1:0]     enable_i,
    input  logic [NFLAG-1:0]     route_i,
    input  logic [NUM_LINES-1:0] lineen_i,
    output logic [NUM_LINES-1:0] irq_o
);
    logic [NFLAG-1:0]     active;
    logic [NUM_LINES-1:0] line_d;
    logic [NUM_LINES-1:0] line_q;

    // Flags that may raise an interrupt at all.
    always_comb active = flags_i & enable_i;

    // One reduction per line, selecting flags whose route matches the line.
    for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
        logic [NFLAG-1:0] pick;
        // Route match for this line.
        always_comb pick = (ln == 0) ? ~route_i : route_i;
        // Gate the OR with the line enable.
        always_comb line_d[ln] = lineen_i[ln] & (|(active & pick));
    end

    // Register the lines for glitch-free outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    // Drive outputs.
    always_comb irq_o = line_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
// Module: top of the two-line interrupt flag controller.
// Edge-set sticky flags, write-one-to-clear, per-flag enable and route, two
// gated registered lines. Assumes all inputs are synchronous to clk.
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int unsigned NFLAG  = 24,
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NFLAG-1:0]     evt_i,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_LINES-1:0] irq_o
);
    logic [NFLAG-1:0]     rise;
    logic [NFLAG-1:0]     clr;
    logic [NFLAG-1:0]     flags;
    logic [NFLAG-1:0]     enable;
    logic [NFLAG-1:0]     route;
    logic [NUM_LINES-1:0] lineen;

    ifc_edge_detect #(.WIDTH(NFLAG)) u_edge (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rise_o(rise)
    );

    ifc_flag_bank #(.WIDTH(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(rise), .clr_i(clr), .flags_o(flags)
    );

    ifc_cfg_regs #(.NFLAG(NFLAG), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .flags_i(flags), .clr_o(clr),
        .enable_o(enable), .route_o(route), .lineen_o(lineen), .rd_data(rd_data)
    );

    ifc_line_merge #(.NFLAG(NFLAG)) u_merge (
        .clk(clk), .rst_n(rst_n), .flags_i(flags), .enable_i(enable),
        .route_i(route), .lineen_i(lineen), .irq_o(irq_o)
    );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
// Checker: temporal properties of the interrupt flag controller, bound to
// the top. Assumes the internal flag and configuration nets are connected.
module irq_flag_ctrl_chk #(
    parameter int unsigned NFLAG  = 24,
    parameter int unsigned DATA_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NFLAG-1:0] evt_i,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [NFLAG-1:0] flags,
    input logic [NFLAG-1:0] enable,
    input logic [NFLAG-1:0] route,
    input logic [1:0]       lineen,
    input logic [1:0]       irq_o
);
    logic [NFLAG-1:0] evt_d;
    logic             seen;

    // Own copy of event history, valid once one cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_d <= '0;
            seen  <= 1'b0;
        end else begin
            evt_d <= evt_i;
            seen  <= 1'b1;
        end
    end

    // R2: without a flag write, no set flag is lost.
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 2'd0) |=> ((flags & $past(flags)) == $past(flags)));

    // R1: a new flag bit only appears where the event rose.
    p_edge_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seen |=> ((flags & ~$past(flags) & ~($past(evt_i) & ~$past(evt_d))) == '0));

    // R8: an event edge always leaves the flag set, even against a clear.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seen |=> ((flags & ($past(evt_i) & ~$past(evt_d))) == ($past(evt_i) & ~$past(evt_d))));

    // R3: a flag write never sets a bit that was clear unless an edge did.
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> ((flags & $past(wr_data[NFLAG-1:0]) & ~$past(evt_i)) == '0));

    // R7: a disabled line stays low one cycle later.
    p_line_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lineen == 2'b00) |=> (irq_o == 2'b00));

    // R5: with no enabled flags, no line rises.
    p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & enable) == '0) |=> (irq_o == 2'b00));

    // R6: a line-1 assertion needs an enabled flag routed to line 1.
    p_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o[1]) |-> ($past(flags & enable & route) != '0));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NFLAG(NFLAG), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .flags(flags), .enable(enable), .route(route),
    .lineen(lineen), .irq_o(irq_o)
);

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] evt_i = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_flag_ctrl u_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    // Vector table: enable, route, line enable, event pulse, expected lines.
    localparam logic [23:0] V_EN  [NV] = '{24'hFFFFFF, 24'hFFFFFF, 24'h000000, 24'hFFFFFF,
                                          24'h0000F0, 24'hFFFFFF, 24'hFFFFFF, 24'h800000};
    localparam logic [23:0] V_RT  [NV] = '{24'h000000, 24'hFFFFFF, 24'h000000, 24'h000000,
                                          24'h000080, 24'h0000FF, 24'h555555, 24'h800000};
    localparam logic [1:0]  V_LE  [NV] = '{2'b11, 2'b11, 2'b11, 2'b10, 2'b11, 2'b01, 2'b11, 2'b10};
    localparam logic [23:0] V_EV  [NV] = '{24'h000001, 24'h000001, 24'h000001, 24'h800000,
                                          24'h000081, 24'h000101, 24'hC00000, 24'h800000};
    localparam logic [1:0]  V_IRQ [NV] = '{2'b01, 2'b10, 2'b00, 2'b00, 2'b10, 2'b01, 2'b11, 2'b10};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic pulse(input logic [23:0] v);
        @(negedge clk); evt_i = v;
        @(negedge clk); evt_i = '0;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R4: reset state
        check("R4 irq in reset", {30'd0, irq_o}, 32'd0);
        rd(2'd0, d); check("R4 flags in reset", d, 32'd0);
        rd(2'd1, d); check("R4 enable in reset", d, 32'd0);
        rd(2'd3, d); check("R4 lineen in reset", d, 32'd0);
        rst_n = 1'b1;

        // Vector table walk (R5, R6, R7, R9)
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, 32'hFFFFFF);
            wr(2'd1, {8'd0, V_EN[i]});
            wr(2'd2, {8'd0, V_RT[i]});
            wr(2'd3, {30'd0, V_LE[i]});
            pulse(V_EV[i]);
            rd(2'd0, d); check($sformatf("R1 vec%0d flags", i), d, {8'd0, V_EV[i]});
            @(negedge clk);
            check($sformatf("R5 R6 R7 vec%0d irq", i), {30'd0, irq_o}, {30'd0, V_IRQ[i]});
        end

        // R9: one-cycle latency of the lines
        wr(2'd0, 32'hFFFFFF);
        wr(2'd1, 32'hFFFFFF); wr(2'd2, 32'd0); wr(2'd3, 32'd3);
        @(negedge clk);
        pulse(24'h000010);
        check("R9 irq not yet", {30'd0, irq_o}, 32'd0);
        @(negedge clk);
        check("R9 irq after one clock", {30'd0, irq_o}, 32'd1);

        // R2: flag stays after the event falls
        repeat (3) @(negedge clk);
        rd(2'd0, d); check("R2 sticky", d, 32'h000010);

        // R3: writing zeros has no effect; single one clears one bit
        pulse(24'h000300);
        wr(2'd0, 32'd0);
        rd(2'd0, d); check("R3 write zero no effect", d, 32'h000310);
        wr(2'd0, 32'h000100);
        rd(2'd0, d); check("R3 one bit cleared", d, 32'h000210);
        wr(2'd0, 32'hFFFFFF);
        rd(2'd0, d); check("R3 all cleared", d, 32'd0);
        @(negedge clk);
        check("R3 irq drops after clear", {30'd0, irq_o}, 32'd0);

        // R1: a held level sets once; after a clear it does not re-set
        @(negedge clk); evt_i = 24'h000004;
        repeat (3) @(negedge clk);
        wr(2'd0, 32'h000004);
        repeat (2) @(negedge clk);
        rd(2'd0, d); check("R1 held level no re-set", d, 32'd0);
        evt_i = '0; @(negedge clk);
        evt_i = 24'h000004; @(negedge clk);
        rd(2'd0, d); check("R1 new edge sets", d, 32'h000004);
        evt_i = '0;
        wr(2'd0, 32'hFFFFFF);

        // R8: edge and clear in the same cycle
        @(negedge clk);
        evt_i = 24'h000040; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h000040;
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0; wr_data = '0;
        rd(2'd0, d); check("R8 set wins over clear", d, 32'h000040);

        // R10: unused bits read zero
        wr(2'd1, 32'hFFFFFFFF);
        rd(2'd1, d); check("R10 enable width", d, 32'h00FFFFFF);
        wr(2'd3, 32'hFFFFFFFF);
        rd(2'd3, d); check("R10 lineen width", d, 32'h00000003);
        wr(2'd2, 32'hA5A5A5A5);
        rd(2'd2, d); check("R10 route readback", d, 32'h00A5A5A5);

        // R4: reset in mid-run clears flags, config and lines
        pulse(24'h000001);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R4 irq after reset", {30'd0, irq_o}, 32'd0);
        rd(2'd0, d); check("R4 flags after reset", d, 32'd0);
        rd(2'd2, d); check("R4 route after reset", d, 32'd0);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule